// File: doc/BRIEF.md
# Polyphase Resampling FIR Engine

This engine produces one output sample for each output-rate strobe. On a strobe it takes a start address into an external sample buffer, a 20-bit fractional phase (2^20 steps between neighbouring input samples), a per-tap coefficient step and a convolution length. It then runs exactly one convolution over consecutive buffer words. It never computes the full zero-stuffed interpolated stream.

Coefficients come from a sparse prototype table. The table holds 2^PH_BITS entries per tap, and the coefficient for any phase between two stored entries is a linear blend of those two entries. When decimating, the rate-tracking logic supplies a longer length and a smaller coefficient step. This stretches the prototype across more input samples, which lowers the cutoff. The sum is kept in a wide accumulator and is saturated to the sample width before it is presented.

Top module: `rsfir_engine`

## Requirements
- R1: After reset, outValid, busy and overrun are 0 and outData is 0.
- R2: The stored table has TAB_N+1 entries, with TAB_N = 64*16 = 1024. Entry p = 32*(512-|p-512|), so entries 0 and 1024 are 0. For a prototype position pos (16 fraction bits per entry), idx = pos>>16 and fr = pos mod 65536. The coefficient is 0 when idx >= 1024. Otherwise it is e[idx] + floor((e[idx+1]-e[idx])*fr / 65536).
- R3: Tap i reads buffer word (startAddr+i) mod 512 at prototype position pos_i = floor(phase*coefStep/2^20) + i*coefStep. outData = floor(sum of word_i*coef_i / 2^19), saturated as in R5.
- R4: The effective length is convLen, with 0 treated as 1 and values above MAX_LEN = 496 clamped to 496.
- R5: Results above 32767 become 32767, and results below -32768 become -32768.
- R6: busy is 1 from the cycle after the accepting edge until the result is presented. It is 0 in the cycle in which outValid is 1.
- R7: A strobe arriving while busy is ignored: it produces no result and changes no parameter. It sets overrun, which then stays 1 until reset.
- R8: Each accepted strobe gives exactly one outValid pulse, one cycle wide. The pulse appears L+3 rising edges after the accepting edge, where L is the effective length.
- R9: rdEn is 1 for exactly L cycles per convolution, with rdAddr stepping by one and wrapping at 512. The buffer returns data one cycle after rdEn.
- R10: A strobe in the same cycle as outValid is accepted and starts a new convolution.
- R11: With coefStep = 2^20 and phase 0, a constant buffer value v of moderate size gives outData = v (unity DC gain over 64 taps). Halving coefStep and doubling the length doubles that gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Output-rate request |
| startAddr | input | 9 | First buffer word of the convolution |
| phase | input | 20 | Fractional phase between input samples |
| coefStep | input | 21 | Prototype advance per tap (2^20 = one tap) |
| convLen | input | 9 | Requested tap count |
| rdEn | output | 1 | Buffer read enable |
| rdAddr | output | 9 | Buffer read address |
| rdData | input | 16 | Buffer data, one cycle after rdEn |
| outData | output | 16 | Saturated output sample |
| outValid | output | 1 | Result strobe |
| busy | output | 1 | Convolution in progress |
| overrun | output | 1 | Sticky flag for a strobe lost while busy |

## Verification
Presenting a finished result and accepting the next strobe can happen in the same cycle. The bench provokes this by raising strobe in exactly the cycle in which it sees outValid. It then requires the old result to match its queued value while the new convolution produces its own correct value and latency. A scoreboard also counts the reads of each convolution. A strobe raised in the middle of a run must yield no second result and must set overrun.

// File: rtl/rsfir_pkg.sv
package rsfir_pkg;

  typedef struct packed {
    logic load;
    logic prep;
    logic issue;
    logic finish;
  } ctrl_t;

  function automatic int kernelAt(input int p, input int half, input int peak);
    int d;
    d = (p > half) ? (p - half) : (half - p);
    if (d > half) return 0;
    return (peak / half) * (half - d);
  endfunction

endpackage

// File: rtl/rsfir_coef_interp.sv
module rsfir_coef_interp #(
  parameter int COEF_W  = 16,
  parameter int TAB_N   = 1024,
  parameter int IDX_W   = 14,
  parameter int FRAC_W  = 16
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic [FRAC_W-1:0]        frac,
  output logic signed [COEF_W-1:0] coef
);
  import rsfir_pkg::*;

  localparam int HALF  = TAB_N / 2;
  localparam int PEAK  = 2 ** (COEF_W - 2);
  localparam int SEL_W = $clog2(TAB_N + 1);
  localparam int DIF_W = COEF_W + 1;
  localparam int MUL_W = DIF_W + FRAC_W + 1;

  logic signed [COEF_W-1:0] table_q [TAB_N+1];

  for (genvar g = 0; g <= TAB_N; g++) begin : g_tab
    assign table_q[g] = COEF_W'(kernelAt(g, HALF, PEAK));
  end

  logic                    inRange;
  logic [SEL_W-1:0]        sel;
  logic signed [DIF_W-1:0] diff;
  logic signed [MUL_W-1:0] blend;

  always_comb begin
    inRange = (idx < IDX_W'(TAB_N));
    sel     = inRange ? SEL_W'(idx) : '0;
    diff    = DIF_W'(table_q[sel + SEL_W'(1)]) - DIF_W'(table_q[sel]);
    blend   = MUL_W'(diff) * $signed(MUL_W'({1'b0, frac}));
    if (inRange)
      coef = COEF_W'(table_q[sel] + COEF_W'(blend >>> FRAC_W));
    else
      coef = '0;
  end

endmodule

// File: rtl/rsfir_ctrl.sv
module rsfir_ctrl #(
  parameter int MAX_LEN = 496,
  parameter int LEN_W   = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobe,
  input  logic [LEN_W-1:0] convLen,
  output rsfir_pkg::ctrl_t ctl,
  output logic [LEN_W-1:0] tapIdx,
  output logic             busy,
  output logic             overrun
);
  import rsfir_pkg::*;

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_RUN, S_DRAIN, S_FIN} state_t;

  state_t           state;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] tapCnt;
  logic [LEN_W-1:0] lenClamped;

  always_comb begin
    if (convLen == '0)                  lenClamped = LEN_W'(1);
    else if (convLen > LEN_W'(MAX_LEN)) lenClamped = LEN_W'(MAX_LEN);
    else                                lenClamped = convLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      lenQ    <= LEN_W'(1);
      tapCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      if (strobe && state != S_IDLE) overrun <= 1'b1;
      unique case (state)
        S_IDLE: if (strobe) begin
          lenQ   <= lenClamped;
          tapCnt <= '0;
          state  <= S_PREP;
        end
        S_PREP: state <= S_RUN;
        S_RUN: begin
          if (tapCnt == lenQ - LEN_W'(1)) state <= S_DRAIN;
          else tapCnt <= tapCnt + LEN_W'(1);
        end
        S_DRAIN: state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = (state == S_IDLE) && strobe;
    ctl.prep   = (state == S_PREP);
    ctl.issue  = (state == S_RUN);
    ctl.finish = (state == S_FIN);
  end

  assign tapIdx = tapCnt;
  assign busy   = (state != S_IDLE);

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && busy) |=> overrun);
  p_tap_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> (tapCnt < lenQ && lenQ <= LEN_W'(MAX_LEN) && lenQ != '0));

endmodule

// File: rtl/rsfir_datapath.sv
module rsfir_datapath #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 16,
  parameter int PHASE_W   = 20,
  parameter int ADDR_W    = 9,
  parameter int LEN_W     = 9,
  parameter int NTAPS     = 64,
  parameter int PH_BITS   = 4,
  parameter int RES_SHIFT = 19,
  parameter int ACC_GUARD = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rsfir_pkg::ctrl_t           ctl,
  input  logic [LEN_W-1:0]           tapIdx,
  input  logic [ADDR_W-1:0]          startAddr,
  input  logic [PHASE_W-1:0]         phase,
  input  logic [PHASE_W:0]           coefStep,
  output logic [ADDR_W-1:0]          rdAddr,
  input  logic signed [SAMPLE_W-1:0] rdData,
  output logic signed [SAMPLE_W-1:0] outData,
  output logic                       outValid
);
  import rsfir_pkg::*;

  localparam int TAB_N  = NTAPS << PH_BITS;
  localparam int FRAC_W = PHASE_W - PH_BITS;
  localparam int POS_W  = PHASE_W + LEN_W + 1;
  localparam int IDX_W  = POS_W - FRAC_W;
  localparam int PROD_W = 2 * PHASE_W + 1;
  localparam int MUL_W  = SAMPLE_W + COEF_W;
  localparam int ACC_W  = MUL_W + ACC_GUARD;
  localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_MIN = -ACC_W'(2 ** (SAMPLE_W - 1));

  logic [ADDR_W-1:0]        startQ;
  logic [PHASE_W-1:0]       phaseQ;
  logic [PHASE_W:0]         stepQ;
  logic [POS_W-1:0]         posQ;
  logic [IDX_W-1:0]         idxQ;
  logic [FRAC_W-1:0]        fracQ;
  logic                     macEn;
  logic signed [ACC_W-1:0]  accQ;
  logic signed [COEF_W-1:0] coef;
  logic signed [MUL_W-1:0]  product;

  rsfir_coef_interp #(
    .COEF_W(COEF_W), .TAB_N(TAB_N), .IDX_W(IDX_W), .FRAC_W(FRAC_W)
  ) coef_i (
    .idx(idxQ), .frac(fracQ), .coef(coef)
  );

  assign product = MUL_W'(rdData) * MUL_W'(coef);
  assign rdAddr  = startQ + ADDR_W'(tapIdx);

  function automatic logic signed [SAMPLE_W-1:0] saturate(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] s;
    s = v >>> RES_SHIFT;
    if (s > SAT_MAX)      return SAT_MAX[SAMPLE_W-1:0];
    else if (s < SAT_MIN) return SAT_MIN[SAMPLE_W-1:0];
    else                  return s[SAMPLE_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ   <= '0;
      phaseQ   <= '0;
      stepQ    <= '0;
      posQ     <= '0;
      idxQ     <= '0;
      fracQ    <= '0;
      macEn    <= 1'b0;
      accQ     <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      macEn    <= ctl.issue;
      outValid <= ctl.finish;
      if (ctl.load) begin
        startQ <= startAddr;
        phaseQ <= phase;
        stepQ  <= coefStep;
        accQ   <= '0;
      end else if (macEn) begin
        accQ <= accQ + ACC_W'(product);
      end
      if (ctl.prep)
        posQ <= POS_W'((PROD_W'(phaseQ) * PROD_W'(stepQ)) >> PHASE_W);
      else if (ctl.issue) begin
        idxQ  <= posQ[POS_W-1:FRAC_W];
        fracQ <= posQ[FRAC_W-1:0];
        posQ  <= posQ + POS_W'(stepQ);
      end
      if (ctl.finish) outData <= saturate(accQ);
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);
  p_mac_after_issue_r3: assert property (@(posedge clk) disable iff (!rstN)
    macEn |-> $past(ctl.issue));

endmodule

// File: rtl/rsfir_engine.sv
module rsfir_engine #(
  parameter int SAMPLE_W  = 16,
  parameter int COEF_W    = 16,
  parameter int PHASE_W   = 20,
  parameter int ADDR_W    = 9,
  parameter int LEN_W     = 9,
  parameter int NTAPS     = 64,
  parameter int PH_BITS   = 4,
  parameter int MAX_LEN   = 496,
  parameter int RES_SHIFT = 19,
  parameter int ACC_GUARD = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       strobe,
  input  logic [ADDR_W-1:0]          startAddr,
  input  logic [PHASE_W-1:0]         phase,
  input  logic [PHASE_W:0]           coefStep,
  input  logic [LEN_W-1:0]           convLen,
  output logic                       rdEn,
  output logic [ADDR_W-1:0]          rdAddr,
  input  logic signed [SAMPLE_W-1:0] rdData,
  output logic signed [SAMPLE_W-1:0] outData,
  output logic                       outValid,
  output logic                       busy,
  output logic                       overrun
);
  import rsfir_pkg::*;

  ctrl_t            ctl;
  logic [LEN_W-1:0] tapIdx;

  rsfir_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convLen(convLen),
    .ctl(ctl), .tapIdx(tapIdx), .busy(busy), .overrun(overrun)
  );

  rsfir_datapath #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .PHASE_W(PHASE_W), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .NTAPS(NTAPS), .PH_BITS(PH_BITS), .RES_SHIFT(RES_SHIFT),
    .ACC_GUARD(ACC_GUARD)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tapIdx(tapIdx),
    .startAddr(startAddr), .phase(phase), .coefStep(coefStep),
    .rdAddr(rdAddr), .rdData(rdData), .outData(outData), .outValid(outValid)
  );

  assign rdEn = ctl.issue;

  p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !busy);
  p_read_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> busy);

endmodule

// File: tb/rsfir_engine_tb.sv
module rsfir_engine_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobe = 1'b0;
  logic [8:0]  startAddr = '0;
  logic [19:0] phase = '0;
  logic [20:0] coefStep = '0;
  logic [8:0]  convLen = '0;
  logic        rdEn;
  logic [8:0]  rdAddr;
  logic signed [15:0] rdData = '0;
  logic signed [15:0] outData;
  logic outValid, busy, overrun;

  always #10 clk = ~clk;

  rsfir_engine dut_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .phase(phase), .coefStep(coefStep), .convLen(convLen),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .outData(outData), .outValid(outValid), .busy(busy), .overrun(overrun)
  );

  logic signed [15:0] bufMem [512];
  always @(posedge clk) if (rdEn) rdData <= bufMem[rdAddr];

  int total = 0;
  int bad = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    longint value;
    longint due;
    int     len;
    string  tag;
  } item_t;
  item_t q[$];
  int rdSeen = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint kern(input longint p);
    longint d;
    d = (p > 512) ? p - 512 : 512 - p;
    if (d > 512) return 0;
    return 32 * (512 - d);
  endfunction

  function automatic longint coefAt(input longint pos);
    longint idx, fr, c0, c1;
    idx = pos >>> 16;
    fr  = pos & 65535;
    if (idx >= 1024) return 0;
    c0 = kern(idx);
    c1 = kern(idx + 1);
    return c0 + (((c1 - c0) * fr) >>> 16);
  endfunction

  function automatic int effLen(input int n);
    if (n == 0) return 1;
    if (n > 496) return 496;
    return n;
  endfunction

  function automatic longint model(input int st, input longint ph, input longint step, input int n);
    longint acc, pos, r;
    int l;
    l = effLen(n);
    acc = 0;
    pos = (ph * step) >>> 20;
    for (int i = 0; i < l; i++) begin
      acc += longint'(bufMem[(st + i) % 512]) * coefAt(pos);
      pos += step;
    end
    r = acc >>> 19;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic fire(input int st, input int ph, input int step, input int n, input string tag);
    item_t it;
    startAddr = 9'(st); phase = 20'(ph); coefStep = 21'(step); convLen = 9'(n);
    strobe = 1'b1;
    it.value = model(st, ph, step, n);
    it.due   = cyc + effLen(n) + 4;
    it.len   = effLen(n);
    it.tag   = tag;
    q.push_back(it);
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy || q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fillConst(input int v);
    for (int a = 0; a < 512; a++) bufMem[a] = 16'(v);
  endtask

  task automatic fillRamp();
    for (int a = 0; a < 512; a++) bufMem[a] = 16'((a * 37) % 2001 - 1000);
  endtask

  always @(negedge clk) begin
    item_t it;
    if (rstN && rdEn) rdSeen++;
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        check(1'b0, "R7/R8 unexpected result", outData, 0);
      end else begin
        it = q.pop_front();
        check(outData == 16'(it.value), {it.tag, " data"}, outData, it.value);
        check(cyc == it.due, "R8 latency", cyc, it.due);
        check(rdSeen == it.len, "R9 read count", rdSeen, it.len);
        check(!busy, "R6 busy low with result", busy, 0);
      end
      rdSeen = 0;
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fillConst(0);
    repeat (3) @(negedge clk);
    check(outValid == 0 && busy == 0 && overrun == 0, "R1 flags", {outValid, busy, overrun}, 0);
    check(outData == 0, "R1 data", outData, 0);
    rstN = 1'b1;
    @(negedge clk);

    fillConst(1000);
    fire(0, 0, 1 << 20, 64, "R11 unity DC");
    check(busy == 1, "R6 busy during run", busy, 1);
    waitIdle();
    check(q.size() == 0, "R11 drained", q.size(), 0);

    fillRamp();
    fire(500, 20'h40000, 1 << 20, 64, "R3 wrap ramp");
    waitIdle();
    fire(7, 20'h12345, 1 << 20, 64, "R2 fractional phase");
    waitIdle();
    fire(100, 20'hFFFFF, 1 << 20, 64, "R2 top phase");
    waitIdle();

    fillConst(1000);
    fire(0, 0, 1 << 19, 128, "R11 stretched gain");
    waitIdle();
    fillRamp();
    fire(300, 20'h2A5A5, 3 << 18, 86, "R3 decimate ramp");
    waitIdle();

    fillConst(32767);
    fire(0, 0, 1 << 19, 128, "R5 saturate high");
    waitIdle();
    fillConst(-32768);
    fire(40, 0, 1 << 19, 128, "R5 saturate low");
    waitIdle();

    fillConst(20);
    fire(0, 0, 1 << 18, 500, "R4 clamp max");
    waitIdle();
    fillRamp();
    fire(9, 20'h80000, 1 << 20, 0, "R4 zero length");
    waitIdle();

    check(overrun == 0, "R7 no overrun yet", overrun, 0);
    fire(20, 20'h33333, 1 << 20, 64, "R7 first of pair");
    repeat (5) @(negedge clk);
    startAddr = 9'd200; phase = 20'h1; coefStep = 21'd5; convLen = 9'd3;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(overrun == 1, "R7 overrun set", overrun, 1);
    waitIdle();
    repeat (80) @(negedge clk);
    check(q.size() == 0 && overrun == 1, "R7 ignored strobe", q.size(), 0);

    fire(60, 20'h0F0F0, 1 << 20, 16, "R10 first");
    while (!outValid) @(negedge clk);
    fire(61, 20'h70000, 1 << 20, 24, "R10 back-to-back");
    check(busy == 1, "R10 second accepted", busy, 1);
    waitIdle();
    check(overrun == 1, "R7 sticky", overrun, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule